// File: doc/BRIEF.md
# PHY Ready Watchdog Timer

This block runs on the transmit clock and watches the PHY-ready status line. While the PHY reports not ready and the watchdog is enabled, a 19-bit down-counter counts down once per clock. When it reaches zero, the block emits a one-cycle PHY reset request. That request makes the PHY start its out-of-band link initialisation again, so a link that has stalled gets a fresh attempt without a full system reset.

The start value is the 10-bit timeout field placed above nine zero bits, so each step of the field is worth 512 clocks. The counter reloads this start value whenever PHY-ready is high, whenever the watchdog is disabled, and right after each expiry. A not-ready episode is therefore always timed from the beginning, and a PHY that stays down is reset again and again. A sticky status flag records that a timeout has occurred until it is cleared.

Top module: `phy_rdy_wdog`

## Requirements
- R1: The start value is {tmo_field, 9'b0}. Suppose the counter has been reloaded and PHY-ready first samples low at clock edge E, with the watchdog enabled. Then phy_rst_o is high in the cycle after edge E+L, where L is the start value.
- R2: The counter decreases by one on each clock edge where enable is set, PHY-ready is low, the count is non-zero and no reset pulse is active. Otherwise it never counts down.
- R3: An edge that samples PHY-ready high reloads the counter with the full start value, so that a later not-ready episode again takes L+1 edges to expire.
- R4: While enable is low, phy_rst_o stays low and the counter holds the start value. After enable is set, expiry takes the full R1 time.
- R5: phy_rst_o is high for exactly one cycle. If PHY-ready stays low, further pulses follow every L+2 cycles.
- R6: tmo_sts_o is set in the same cycle as the reset pulse and stays set until an edge samples sts_clr high. If expiry and sts_clr coincide, setting wins.
- R7: A timeout field of zero gives a start value of zero. This is a degenerate setting: the pulse appears in the cycle after the first not-ready edge and then repeats every second cycle.
- R8: Synchronous active-high reset drives phy_rst_o and tmo_sts_o low and loads the counter with the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Watchdog enable |
| phy_rdy | input | 1 | PHY-ready status, already synchronous to clk |
| tmo_field | input | 10 | Timeout field, 512-clock units |
| sts_clr | input | 1 | Clears the sticky timeout flag |
| phy_rst_o | output | 1 | One-cycle PHY reset request |
| tmo_sts_o | output | 1 | Sticky timeout flag |

## Verification
The reset pulse is due in the cycle after edge E+L, where E is the first edge that samples PHY-ready low; repeat pulses come every L+2 cycles after that. The status flag changes on the same edge as the pulse, and a clear takes effect one edge after sts_clr is driven. The driver computes each due cycle from the edge count at the moment it drops PHY-ready, and queues it. The monitor samples on the falling clock edge and reports any pulse that arrives early, late, unexpected or not at all.

// File: rtl/phy_rdy_wdog_pkg.sv
package phy_rdy_wdog_pkg;
  localparam int FIELD_W = 10;
  localparam int PAD_W   = 9;
  localparam int CNT_W   = FIELD_W + PAD_W;

  function automatic logic [CNT_W-1:0] start_value(input logic [FIELD_W-1:0] f);
    return {f, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/phy_rdy_wdog_load.sv
module phy_rdy_wdog_load #(
  parameter int FIELD_W = 10,
  parameter int PAD_W   = 9,
  localparam int CNT_W  = FIELD_W + PAD_W
) (
  input  logic [FIELD_W-1:0] field_i,
  output logic [CNT_W-1:0]   load_o
);
  // Field forms the upper bits; low bits are zero padding.
  always_comb begin
    load_o = '0;
    load_o[CNT_W-1:PAD_W] = field_i;
  end
endmodule

// File: rtl/phy_rdy_wdog_cnt.sv
module phy_rdy_wdog_cnt #(
  parameter int CNT_W = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  always_ff @(posedge clk) begin
    if (rst || reload_i) cnt_o <= load_i;
    else if (cnt_o != '0) cnt_o <= cnt_o - CNT_W'(1);
  end

  assign zero_o = (cnt_o == '0);
endmodule

// File: rtl/phy_rdy_wdog_flag.sv
module phy_rdy_wdog_flag (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic clr_i,
  output logic pulse_o,
  output logic sts_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o <= 1'b0;
      sts_o   <= 1'b0;
    end else begin
      pulse_o <= expire_i;
      if (expire_i)   sts_o <= 1'b1;
      else if (clr_i) sts_o <= 1'b0;
    end
  end

  // R6: set takes priority over clear
  p_sts_with_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> sts_o);
endmodule

// File: rtl/phy_rdy_wdog.sv
module phy_rdy_wdog #(
  parameter int FIELD_W = phy_rdy_wdog_pkg::FIELD_W,
  parameter int PAD_W   = phy_rdy_wdog_pkg::PAD_W,
  localparam int CNT_W  = FIELD_W + PAD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               phy_rdy,
  input  logic [FIELD_W-1:0] tmo_field,
  input  logic               sts_clr,
  output logic               phy_rst_o,
  output logic               tmo_sts_o
);
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] cnt;
  logic             cnt_zero;
  logic             expire;
  logic             reload;

  phy_rdy_wdog_load #(.FIELD_W(FIELD_W), .PAD_W(PAD_W)) u_load (
    .field_i (tmo_field),
    .load_o  (load_val)
  );

  // Expiry is blocked during the pulse cycle so the output stays one cycle wide.
  assign expire = en && !phy_rdy && cnt_zero && !phy_rst_o;
  assign reload = !en || phy_rdy || expire || phy_rst_o;

  phy_rdy_wdog_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .reload_i (reload),
    .load_i   (load_val),
    .cnt_o    (cnt),
    .zero_o   (cnt_zero)
  );

  phy_rdy_wdog_flag u_flag (
    .clk      (clk),
    .rst      (rst),
    .expire_i (expire),
    .clr_i    (sts_clr),
    .pulse_o  (phy_rst_o),
    .sts_o    (tmo_sts_o)
  );

  p_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !phy_rdy && !cnt_zero && !phy_rst_o) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_reload_ready_r3: assert property (@(posedge clk) disable iff (rst)
    phy_rdy |=> (cnt == $past(load_val)));

  p_off_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> !phy_rst_o);

  p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
    phy_rst_o |=> !phy_rst_o);

  p_fire_r7: assert property (@(posedge clk) disable iff (rst)
    (en && !phy_rdy && cnt_zero && !phy_rst_o) |=> phy_rst_o);

  p_reset_r8: assert property (@(posedge clk)
    rst |=> (!phy_rst_o && !tmo_sts_o));
endmodule

// File: tb/phy_rdy_wdog_tb.sv
module phy_rdy_wdog_tb;
  typedef struct { int cyc; string tag; } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       phy_rdy = 1'b1;
  logic [9:0] tmo_field = 10'd1;
  logic       sts_clr = 1'b0;
  logic       phy_rst_o;
  logic       tmo_sts_o;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  phy_rdy_wdog u_dut (
    .clk(clk), .rst(rst), .en(en), .phy_rdy(phy_rdy), .tmo_field(tmo_field),
    .sts_clr(sts_clr), .phy_rst_o(phy_rst_o), .tmo_sts_o(tmo_sts_o)
  );

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic push(input int c, input string tag);
    exp_t e;
    e.cyc = c;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: sampled on falling edge
  always @(negedge clk) begin
    if (!rst) begin
      while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        check(1'b0, {exp_q[0].tag, " missed pulse"}, cyc, exp_q[0].cyc);
        void'(exp_q.pop_front());
      end
      if (phy_rst_o) begin
        if (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
          check(1'b1, exp_q[0].tag, cyc, cyc);
          void'(exp_q.pop_front());
        end else begin
          check(1'b0, "R5 unexpected pulse", cyc, (exp_q.size() > 0) ? exp_q[0].cyc : -1);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int e;
    idle(3);
    check(phy_rst_o == 1'b0, "R8 reset pulse low", phy_rst_o, 0);
    check(tmo_sts_o == 1'b0, "R8 reset status low", tmo_sts_o, 0);
    rst = 1'b0;
    idle(2);

    // R1 and R5: L = 512, two expiries while not ready
    en = 1'b1;
    idle(2);
    e = cyc + 1;
    phy_rdy = 1'b0;
    push(e + 512, "R1 first expiry");
    push(e + 512 + 514, "R5 repeat expiry");
    wait_to(e + 1027);
    check(tmo_sts_o == 1'b1, "R6 sticky status", tmo_sts_o, 1);
    phy_rdy = 1'b1;
    idle(3);

    // R6: clear
    sts_clr = 1'b1;
    idle(1);
    check(tmo_sts_o == 1'b0, "R6 status cleared", tmo_sts_o, 0);
    sts_clr = 1'b0;

    // R3: ready episode mid-count restarts the timing
    idle(2);
    e = cyc + 1;
    phy_rdy = 1'b0;
    wait_to(e + 300);
    phy_rdy = 1'b1;
    idle(2);
    e = cyc + 1;
    phy_rdy = 1'b0;
    push(e + 512, "R3 full time after ready");
    wait_to(e + 513);
    phy_rdy = 1'b1;
    check(tmo_sts_o == 1'b1, "R6 status after R3 expiry", tmo_sts_o, 1);
    sts_clr = 1'b1;
    idle(1);
    sts_clr = 1'b0;

    // R4: disabled watchdog stays quiet
    idle(2);
    en = 1'b0;
    phy_rdy = 1'b0;
    idle(1500);
    check(phy_rst_o == 1'b0, "R4 no pulse while disabled", phy_rst_o, 0);
    check(tmo_sts_o == 1'b0, "R4 no status while disabled", tmo_sts_o, 0);
    e = cyc + 1;
    en = 1'b1;
    push(e + 512, "R4 full time after enable");
    wait_to(e + 513);
    phy_rdy = 1'b1;
    idle(3);

    // R1 and R2: field 3 -> 1536 clocks
    tmo_field = 10'd3;
    idle(2);
    e = cyc + 1;
    phy_rdy = 1'b0;
    push(e + 1536, "R2 field 3 countdown");
    wait_to(e + 1537);
    phy_rdy = 1'b1;
    idle(3);

    // R7: zero field, with clear held (R6 set wins)
    tmo_field = 10'd0;
    idle(2);
    sts_clr = 1'b1;
    e = cyc + 1;
    phy_rdy = 1'b0;
    push(e, "R7 zero field first");
    push(e + 2, "R7 zero field second");
    push(e + 4, "R7 zero field third");
    wait_to(e);
    check(tmo_sts_o == 1'b1, "R6 set wins over clear", tmo_sts_o, 1);
    wait_to(e + 1);
    check(tmo_sts_o == 1'b0, "R6 clear after pulse", tmo_sts_o, 0);
    wait_to(e + 5);
    phy_rdy = 1'b1;
    sts_clr = 1'b0;
    idle(5);

    check(exp_q.size() == 0, "R5 all pulses seen", exp_q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule